// File: doc/BRIEF.md
# Prescaled Real-Time Seconds Counter with Alarm

This block keeps time for a chip in seconds. A slow clock source, chosen from three candidate oscillator strobes, feeds a 20-bit down-counting divider. Each time the divider passes zero it emits one tick and reloads, so the tick rate is the source rate divided by the reload value plus one. Every tick advances a 32-bit seconds counter. Hardware compares the counter with a 32-bit alarm and watches for it rolling over. Each of the three events (tick, alarm match, rollover) latches a flag, and the flag can raise the interrupt line when its enable is set.

Software reaches the block through a 16-bit register port. The divider reload, the counter and the alarm can only be changed inside a configuration window. Values written inside the window are held in staging registers. When the window closes they are handed to the timekeeping logic all at once on the next slow strobe. A write-done bit shows when the handover is complete. A synchronised bit, which software clears, comes back on the next slow strobe. Its return shows that the values read back are fresh.

The slow domain runs on the bus clock, gated by the selected strobe. A two-stage synchroniser releases the reset.

Top module: `rtc_alarm_counter`

## Requirements
- R1: After reset the control word at offset 0 reads 0x0020 (only write-done set), the counter reads 0, the divider reload and the live divider both read the reset reload value, the alarm reads 0xFFFFFFFF, and irq is low.
- R2: Writes to the reload (offsets 2, 3), counter (offsets 6, 7) and alarm (offsets 8, 9) registers are ignored unless configuration mode, bit 4 of offset 0, reads 1.
- R3: Configuration mode is closed by writing 0 to bit 4 of offset 0. If any timing register was written while the window was open, write-done (bit 5) then reads 0. On the next enabled slow strobe, every staged group lands in the timekeeping logic in the same cycle and write-done returns to 1.
- R4: A write that sets bit 4 of offset 0 while write-done reads 0 leaves configuration mode off.
- R5: Offset 10 selects the slow strobe. Bits 1:0 choose the source: 00 none, 01 src_tick[0], 10 src_tick[1], 11 src_tick[2]. Bit 2 enables the block. Without an enabled, selected strobe, nothing in the timekeeping logic advances.
- R6: The divider steps down by one on each enabled strobe. On a strobe where it holds zero, it emits a tick and reloads, so ticks come every reload+1 strobes. Its live value reads at offsets 4 (bits 15:0) and 5 (bits 19:16).
- R7: Each tick increments the counter, which reads at offsets 6 (low half) and 7 (high half).
- R8: The alarm flag (bit 1 of offset 0) sets on the tick at which the counter becomes equal to the alarm value.
- R9: The overflow flag (bit 2 of offset 0) sets on the tick at which the counter wraps from 0xFFFFFFFF to 0.
- R10: Writing 0 to a flag bit (bit 0 seconds, bit 1 alarm, bit 2 overflow) at offset 0 clears it, writing 1 leaves it unchanged, and configuration mode is not needed. A hardware set in the same cycle as a clear wins.
- R11: The synchronised flag (bit 3 of offset 0) is cleared by writing 0 to it and set by hardware on the next enabled slow strobe.
- R12: irq is high while any flag is set together with its enable at offset 1 (bit 0 seconds, bit 1 alarm, bit 2 overflow).
- R13: Offset 3 stores only bits 3:0 of the written data, which hold reload bits 19:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | One-cycle strobes from the three slow clock sources |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a software flag clear that lands in the same cycle as the strobe on which the divider hits zero. This is made harder because the counter must also sit one step below rollover and one step below the alarm. The stimulus first shrinks the reload to 3 and stages a counter of 0xFFFFFFFE through a configuration window. It then issues slow strobes one at a time, so the tick, wrap and alarm cycles fall on known strobe counts. A behavioural model in the bench follows every cycle, so any divergence in a read-back value or in irq shows up at once.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NSRC   = 3;
  localparam int unsigned NFLAG  = 3;
  localparam int unsigned NGRP   = 3;

  // register offsets
  localparam logic [ADDR_W-1:0] A_CTRL_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRE_LO  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PRE_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DIV_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DIV_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALM_LO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_ALM_HI  = 4'd9;
  localparam logic [ADDR_W-1:0] A_CLK     = 4'd10;

  // control word bit positions; flag bits double as event indices
  localparam int unsigned B_SEC  = 0;
  localparam int unsigned B_ALM  = 1;
  localparam int unsigned B_OVF  = 2;
  localparam int unsigned B_SYNC = 3;
  localparam int unsigned B_CFG  = 4;
  localparam int unsigned B_DONE = 5;

  // staged register groups
  localparam int unsigned G_PRE = 0;
  localparam int unsigned G_CNT = 1;
  localparam int unsigned G_ALM = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned      PRE_W   = 20,
  parameter logic [PRE_W-1:0] PRE_RST = 20'h07FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st,
  input  logic             ld,
  input  logic [PRE_W-1:0] ld_val,
  output logic             tick,
  output logic [PRE_W-1:0] div
);
  logic [PRE_W-1:0] reload_q, reload_d;
  logic [PRE_W-1:0] div_q, div_d;

  always_comb begin
    reload_d = reload_q;
    div_d    = div_q;
    if (ld) begin
      reload_d = ld_val;
      div_d    = ld_val;
    end else if (st) begin
      div_d = (div_q == '0) ? reload_q : div_q - PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= PRE_RST;
      div_q    <= PRE_RST;
    end else if (ld || st) begin
      reload_q <= reload_d;
      div_q    <= div_d;
    end
  end

  assign tick = st && !ld && (div_q == '0);
  assign div  = div_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned      CNT_W   = 32,
  parameter logic [CNT_W-1:0] ALM_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_cnt,
  input  logic             ld_alm,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] alm_val,
  output logic [CNT_W-1:0] cnt,
  output logic             alm_hit,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d, alm_q, alm_d, alm_eff, cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign alm_eff = ld_alm ? alm_val : alm_q;

  always_comb begin
    cnt_d = cnt_q;
    alm_d = alm_q;
    if (ld_cnt)    cnt_d = cnt_val;
    else if (tick) cnt_d = cnt_inc;
    if (ld_alm)    alm_d = alm_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alm_q <= ALM_RST;
    end else begin
      if (ld_cnt || tick) cnt_q <= cnt_d;
      if (ld_alm)         alm_q <= alm_d;
    end
  end

  assign alm_hit = tick && !ld_cnt && (cnt_inc == alm_eff);
  assign wrap    = tick && !ld_cnt && (&cnt_q);
  assign cnt     = cnt_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs import rtc_pkg::*; #(
  parameter int unsigned      PRE_W   = 20,
  parameter int unsigned      CNT_W   = 32,
  parameter logic [PRE_W-1:0] PRE_RST = 20'h07FFF,
  parameter logic [CNT_W-1:0] ALM_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              st,
  input  logic [NFLAG-1:0]  evt,
  input  logic [PRE_W-1:0]  div_live,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic [NGRP-1:0]   ld,
  output logic [PRE_W-1:0]  stg_pre,
  output logic [CNT_W-1:0]  stg_cnt,
  output logic [CNT_W-1:0]  stg_alm,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  ie,
  output logic [1:0]        clk_sel,
  output logic              rtc_en,
  output logic              cfg_mode,
  output logic              wr_done
);
  localparam int unsigned PRE_HI_W = PRE_W - BUS_W;
  localparam int unsigned CNT_HI_W = CNT_W - BUS_W;

  logic                 cfg_q, cfg_d, pend_q, pend_d, sync_q, sync_d, en_q, en_d;
  logic                 exit_cfg;
  logic [NGRP-1:0]      dirty_q, dirty_d;
  logic [NFLAG-1:0]     flags_q, flags_d, ie_q, ie_d;
  logic [1:0]           sel_q, sel_d;
  logic [PRE_W-1:0]     spre_q, spre_d;
  logic [CNT_W-1:0]     scnt_q, scnt_d, salm_q, salm_d;

  always_comb begin
    cfg_d    = cfg_q;
    pend_d   = pend_q;
    sync_d   = sync_q;
    en_d     = en_q;
    dirty_d  = dirty_q;
    flags_d  = flags_q;
    ie_d     = ie_q;
    sel_d    = sel_q;
    spre_d   = spre_q;
    scnt_d   = scnt_q;
    salm_d   = salm_q;
    exit_cfg = 1'b0;
    if (bus_wr) begin
      case (bus_addr)
        A_CTRL_LO: begin
          for (int i = 0; i < int'(NFLAG); i++)
            if (!bus_wdata[i]) flags_d[i] = 1'b0;
          if (!bus_wdata[B_SYNC]) sync_d = 1'b0;
          if (!pend_q) begin
            cfg_d    = bus_wdata[B_CFG];
            exit_cfg = cfg_q && !bus_wdata[B_CFG];
          end
        end
        A_CTRL_HI: ie_d = bus_wdata[NFLAG-1:0];
        A_CLK: begin
          sel_d = bus_wdata[1:0];
          en_d  = bus_wdata[2];
        end
        A_PRE_LO: if (cfg_q) begin
          spre_d[BUS_W-1:0] = bus_wdata;
          dirty_d[G_PRE]    = 1'b1;
        end
        A_PRE_HI: if (cfg_q) begin
          spre_d[PRE_W-1:BUS_W] = bus_wdata[PRE_HI_W-1:0];
          dirty_d[G_PRE]        = 1'b1;
        end
        A_CNT_LO: if (cfg_q) begin
          scnt_d[BUS_W-1:0] = bus_wdata;
          dirty_d[G_CNT]    = 1'b1;
        end
        A_CNT_HI: if (cfg_q) begin
          scnt_d[CNT_W-1:BUS_W] = bus_wdata[CNT_HI_W-1:0];
          dirty_d[G_CNT]        = 1'b1;
        end
        A_ALM_LO: if (cfg_q) begin
          salm_d[BUS_W-1:0] = bus_wdata;
          dirty_d[G_ALM]    = 1'b1;
        end
        A_ALM_HI: if (cfg_q) begin
          salm_d[CNT_W-1:BUS_W] = bus_wdata[CNT_HI_W-1:0];
          dirty_d[G_ALM]        = 1'b1;
        end
        default: ;
      endcase
    end
    if (st && pend_q) begin
      pend_d  = 1'b0;
      dirty_d = '0;
    end else if (exit_cfg && (|dirty_q)) begin
      pend_d = 1'b1;
    end
    if (st) sync_d = 1'b1;
    flags_d = flags_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 1'b0;
      pend_q  <= 1'b0;
      sync_q  <= 1'b0;
      en_q    <= 1'b0;
      dirty_q <= '0;
      flags_q <= '0;
      ie_q    <= '0;
      sel_q   <= '0;
      spre_q  <= PRE_RST;
      scnt_q  <= '0;
      salm_q  <= ALM_RST;
    end else begin
      cfg_q   <= cfg_d;
      pend_q  <= pend_d;
      sync_q  <= sync_d;
      en_q    <= en_d;
      dirty_q <= dirty_d;
      flags_q <= flags_d;
      ie_q    <= ie_d;
      sel_q   <= sel_d;
      spre_q  <= spre_d;
      scnt_q  <= scnt_d;
      salm_q  <= salm_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL_LO: begin
        bus_rdata[NFLAG-1:0] = flags_q;
        bus_rdata[B_SYNC]    = sync_q;
        bus_rdata[B_CFG]     = cfg_q;
        bus_rdata[B_DONE]    = !pend_q;
      end
      A_CTRL_HI: bus_rdata = BUS_W'(ie_q);
      A_PRE_LO:  bus_rdata = spre_q[BUS_W-1:0];
      A_PRE_HI:  bus_rdata = BUS_W'(spre_q[PRE_W-1:BUS_W]);
      A_DIV_LO:  bus_rdata = div_live[BUS_W-1:0];
      A_DIV_HI:  bus_rdata = BUS_W'(div_live[PRE_W-1:BUS_W]);
      A_CNT_LO:  bus_rdata = cnt_live[BUS_W-1:0];
      A_CNT_HI:  bus_rdata = BUS_W'(cnt_live[CNT_W-1:BUS_W]);
      A_ALM_LO:  bus_rdata = salm_q[BUS_W-1:0];
      A_ALM_HI:  bus_rdata = BUS_W'(salm_q[CNT_W-1:BUS_W]);
      A_CLK:     bus_rdata = BUS_W'({en_q, sel_q});
      default:   bus_rdata = '0;
    endcase
  end

  assign ld       = {NGRP{st && pend_q}} & dirty_q;
  assign stg_pre  = spre_q;
  assign stg_cnt  = scnt_q;
  assign stg_alm  = salm_q;
  assign flags    = flags_q;
  assign ie       = ie_q;
  assign clk_sel  = sel_q;
  assign rtc_en   = en_q;
  assign cfg_mode = cfg_q;
  assign wr_done  = !pend_q;
endmodule

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter import rtc_pkg::*; #(
  parameter int unsigned      PRE_W   = 20,
  parameter int unsigned      CNT_W   = 32,
  parameter logic [PRE_W-1:0] PRE_RST = 20'h07FFF,
  parameter logic [CNT_W-1:0] ALM_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             rst_meta, rst_sync_n;
  logic             st, sel_tick, sec_tick, alm_hit, wrap;
  logic             rtc_en, cfg_mode, wr_done;
  logic [1:0]       clk_sel;
  logic [NGRP-1:0]  ld;
  logic [NFLAG-1:0] evt, flags, ie, irq_term;
  logic [PRE_W-1:0] stg_pre, div_live;
  logic [CNT_W-1:0] stg_cnt, stg_alm, cnt_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  always_comb begin
    case (clk_sel)
      2'b01:   sel_tick = src_tick[0];
      2'b10:   sel_tick = src_tick[1];
      2'b11:   sel_tick = src_tick[2];
      default: sel_tick = 1'b0;
    endcase
  end
  assign st = rtc_en && sel_tick;

  rtc_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .PRE_RST(PRE_RST), .ALM_RST(ALM_RST)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st(st), .evt(evt), .div_live(div_live), .cnt_live(cnt_live),
    .ld(ld), .stg_pre(stg_pre), .stg_cnt(stg_cnt), .stg_alm(stg_alm),
    .flags(flags), .ie(ie), .clk_sel(clk_sel), .rtc_en(rtc_en),
    .cfg_mode(cfg_mode), .wr_done(wr_done)
  );

  rtc_prescaler #(.PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .st(st), .ld(ld[G_PRE]), .ld_val(stg_pre),
    .tick(sec_tick), .div(div_live)
  );

  rtc_counter #(.CNT_W(CNT_W), .ALM_RST(ALM_RST)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(sec_tick),
    .ld_cnt(ld[G_CNT]), .ld_alm(ld[G_ALM]), .cnt_val(stg_cnt), .alm_val(stg_alm),
    .cnt(cnt_live), .alm_hit(alm_hit), .wrap(wrap)
  );

  always_comb begin
    evt        = '0;
    evt[B_SEC] = sec_tick;
    evt[B_ALM] = alm_hit;
    evt[B_OVF] = wrap;
  end

  for (genvar g = 0; g < int'(NFLAG); g++) begin : g_irq
    assign irq_term[g] = flags[g] & ie[g];
  end
  assign irq = |irq_term;
endmodule

// File: rtl/rtc_alarm_counter_chk.sv
module rtc_alarm_counter_chk import rtc_pkg::*; #(
  parameter int unsigned PRE_W = 20,
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              st,
  input logic [NFLAG-1:0]  evt,
  input logic [NFLAG-1:0]  flags,
  input logic              cfg_mode,
  input logic              wr_done,
  input logic [PRE_W-1:0]  div_live,
  input logic [CNT_W-1:0]  cnt_live
);
  p_enter_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL_LO && bus_wdata[B_CFG] && !wr_done) |=> !cfg_mode);

  p_done_falls_on_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_done) |-> ($past(cfg_mode) && !cfg_mode));

  p_done_rises_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done) |-> $past(st));

  p_sec_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt[B_SEC] |=> flags[B_SEC]);

  p_alarm_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt[B_ALM] |=> flags[B_ALM]);

  p_wrap_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt[B_OVF] |=> (cnt_live == '0));

  p_counter_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !st |=> $stable(cnt_live));

  p_divider_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !st |=> $stable(div_live));
endmodule

bind rtc_alarm_counter rtc_alarm_counter_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .st(st), .evt(evt), .flags(flags), .cfg_mode(cfg_mode),
  .wr_done(wr_done), .div_live(div_live), .cnt_live(cnt_live)
);

// File: tb/test_rtc_alarm_counter.sv
module test_rtc_alarm_counter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 1'b0;
  bit done_flag = 1'b0;

  rtc_alarm_counter i_rtc_alarm_counter (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  bit          m_cfg, m_pend, m_sync, m_en;
  bit  [2:0]   m_dirty, m_flags, m_ie;
  bit  [1:0]   m_sel;
  bit  [19:0]  m_spre, m_reload, m_div;
  bit  [31:0]  m_scnt, m_salm, m_cnt, m_alm;

  task automatic m_reset();
    m_cfg = 0; m_pend = 0; m_sync = 0; m_en = 0; m_dirty = 0; m_flags = 0;
    m_ie = 0; m_sel = 0; m_spre = 20'h07FFF; m_reload = 20'h07FFF; m_div = 20'h07FFF;
    m_scnt = 0; m_salm = 32'hFFFF_FFFF; m_cnt = 0; m_alm = 32'hFFFF_FFFF;
  endtask

  task automatic m_step();
    bit s, tk, lp, lc, la, ev_s, ev_a, ev_o, old_cfg, old_pend, leave;
    bit [31:0] a_eff;
    bit [2:0]  old_dirty;
    case (m_sel)
      2'd1: s = src_tick[0];
      2'd2: s = src_tick[1];
      2'd3: s = src_tick[2];
      default: s = 0;
    endcase
    s = s && m_en;
    lp = s && m_pend && m_dirty[0];
    lc = s && m_pend && m_dirty[1];
    la = s && m_pend && m_dirty[2];
    tk = s && !lp && (m_div == 0);
    a_eff = la ? m_salm : m_alm;
    ev_s = tk;
    ev_a = tk && !lc && ((m_cnt + 32'd1) == a_eff);
    ev_o = tk && !lc && (m_cnt == 32'hFFFF_FFFF);
    if (lp) begin m_reload = m_spre; m_div = m_spre; end
    else if (s) m_div = (m_div == 0) ? m_reload : m_div - 20'd1;
    if (lc) m_cnt = m_scnt; else if (tk) m_cnt = m_cnt + 32'd1;
    if (la) m_alm = m_salm;
    old_cfg = m_cfg; old_pend = m_pend; old_dirty = m_dirty; leave = 0;
    if (bus_wr) begin
      case (bus_addr)
        4'd0: begin
          for (int i = 0; i < 3; i++) if (!bus_wdata[i]) m_flags[i] = 0;
          if (!bus_wdata[3]) m_sync = 0;
          if (!old_pend) begin leave = old_cfg && !bus_wdata[4]; m_cfg = bus_wdata[4]; end
        end
        4'd1: m_ie = bus_wdata[2:0];
        4'd10: begin m_sel = bus_wdata[1:0]; m_en = bus_wdata[2]; end
        4'd2: if (old_cfg) begin m_spre[15:0] = bus_wdata; m_dirty[0] = 1; end
        4'd3: if (old_cfg) begin m_spre[19:16] = bus_wdata[3:0]; m_dirty[0] = 1; end
        4'd6: if (old_cfg) begin m_scnt[15:0] = bus_wdata; m_dirty[1] = 1; end
        4'd7: if (old_cfg) begin m_scnt[31:16] = bus_wdata; m_dirty[1] = 1; end
        4'd8: if (old_cfg) begin m_salm[15:0] = bus_wdata; m_dirty[2] = 1; end
        4'd9: if (old_cfg) begin m_salm[31:16] = bus_wdata; m_dirty[2] = 1; end
        default: ;
      endcase
    end
    if (s && old_pend) begin m_pend = 0; m_dirty = 0; end
    else if (leave && (old_dirty != 0)) m_pend = 1;
    if (s) m_sync = 1;
    if (ev_s) m_flags[0] = 1;
    if (ev_a) m_flags[1] = 1;
    if (ev_o) m_flags[2] = 1;
  endtask

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {10'd0, !m_pend, m_cfg, m_sync, m_flags};
      4'd1: return {13'd0, m_ie};
      4'd2: return m_spre[15:0];
      4'd3: return {12'd0, m_spre[19:16]};
      4'd4: return m_div[15:0];
      4'd5: return {12'd0, m_div[19:16]};
      4'd6: return m_cnt[15:0];
      4'd7: return m_cnt[31:16];
      4'd8: return m_salm[15:0];
      4'd9: return m_salm[31:16];
      4'd10: return {13'd0, m_en, m_sel};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R10";
      4'd1: return "R12";
      4'd2, 4'd3: return "R13";
      4'd4, 4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !done_flag) begin
      check16(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      check16("R12", {15'd0, irq}, {15'd0, |(m_flags & m_ie)});
    end
  end

  task automatic cyc(input logic w, input logic [3:0] a, input logic [15:0] d, input logic [2:0] s);
    @(posedge clk);
    #1;
    bus_wr = w; bus_addr = a; bus_wdata = d; src_tick = s;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 3'b000);
  endtask

  task automatic pulse(input logic [2:0] s, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 16'd0, s);
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    cyc(1'b0, a, 16'd0, 3'b000);
    @(negedge clk);
    check16(tag, bus_rdata, exp);
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    cyc(1'b0, 4'd0, 16'd0, 3'b000);
    @(negedge clk);
    check16(tag, {15'd0, irq}, {15'd0, exp});
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_on = 1'b1;

    // R1 reset state
    expect_rd(4'd0, 16'h0020, "R1");
    expect_rd(4'd6, 16'h0000, "R1");
    expect_rd(4'd9, 16'hFFFF, "R1");
    expect_rd(4'd2, 16'h7FFF, "R1");
    expect_rd(4'd4, 16'h7FFF, "R1");
    expect_irq(1'b0, "R1");

    // R2 timing writes ignored outside configuration mode
    wr(4'd8, 16'h0005);
    expect_rd(4'd8, 16'hFFFF, "R2");
    wr(4'd2, 16'h0003);
    expect_rd(4'd2, 16'h7FFF, "R2");

    // R5 source selection
    wr(4'd10, 16'h0005);
    expect_rd(4'd10, 16'h0005, "R5");
    pulse(3'b010, 1);
    expect_rd(4'd4, 16'h7FFF, "R5");
    pulse(3'b001, 1);
    expect_rd(4'd4, 16'h7FFE, "R6");
    expect_rd(4'd0, 16'h0028, "R11");

    // configuration window
    wr(4'd0, 16'h001F);
    expect_rd(4'd0, 16'h0038, "R2");
    wr(4'd2, 16'h0003);
    wr(4'd3, 16'hFFF0);
    wr(4'd6, 16'hFFFE);
    wr(4'd7, 16'hFFFF);
    wr(4'd8, 16'h0001);
    wr(4'd9, 16'h0000);
    expect_rd(4'd3, 16'h0000, "R13");
    expect_rd(4'd8, 16'h0001, "R2");
    expect_rd(4'd6, 16'h0000, "R3");
    wr(4'd0, 16'h000F);
    expect_rd(4'd0, 16'h0008, "R3");
    wr(4'd0, 16'h001F);
    expect_rd(4'd0, 16'h0008, "R4");
    pulse(3'b001, 1);
    expect_rd(4'd0, 16'h0028, "R3");
    expect_rd(4'd6, 16'hFFFE, "R3");
    expect_rd(4'd7, 16'hFFFF, "R3");
    expect_rd(4'd4, 16'h0003, "R3");

    // R6 R7 divider period and counting
    pulse(3'b001, 3);
    expect_rd(4'd6, 16'hFFFE, "R6");
    expect_rd(4'd4, 16'h0000, "R6");
    pulse(3'b001, 1);
    expect_rd(4'd6, 16'hFFFF, "R7");
    expect_rd(4'd0, 16'h0029, "R6");
    expect_rd(4'd4, 16'h0003, "R6");

    // R9 wrap
    pulse(3'b001, 4);
    expect_rd(4'd6, 16'h0000, "R9");
    expect_rd(4'd7, 16'h0000, "R9");
    expect_rd(4'd0, 16'h002D, "R9");

    // R8 alarm
    pulse(3'b001, 4);
    expect_rd(4'd6, 16'h0001, "R8");
    expect_rd(4'd0, 16'h002F, "R8");

    // R12 and R10 interrupt and clearing
    expect_irq(1'b0, "R12");
    wr(4'd1, 16'h0002);
    expect_irq(1'b1, "R12");
    wr(4'd0, 16'h000D);
    expect_irq(1'b0, "R10");
    expect_rd(4'd0, 16'h002D, "R10");
    wr(4'd1, 16'h0004);
    expect_irq(1'b1, "R12");
    wr(4'd0, 16'h000B);
    expect_irq(1'b0, "R10");
    expect_rd(4'd0, 16'h0029, "R10");

    // R11 sync flag
    wr(4'd0, 16'h0001);
    expect_rd(4'd0, 16'h0021, "R11");
    pulse(3'b001, 1);
    expect_rd(4'd0, 16'h0029, "R11");

    // R10 hardware set wins over clear in the same cycle
    pulse(3'b001, 2);
    expect_rd(4'd4, 16'h0000, "R6");
    cyc(1'b1, 4'd0, 16'h000E, 3'b001);
    expect_rd(4'd0, 16'h0029, "R10");
    expect_rd(4'd6, 16'h0002, "R7");
    wr(4'd0, 16'h000E);
    expect_rd(4'd0, 16'h0028, "R10");

    // R5 no source, disabled, and third source
    wr(4'd10, 16'h0004);
    pulse(3'b111, 3);
    expect_rd(4'd4, 16'h0003, "R5");
    wr(4'd10, 16'h0001);
    pulse(3'b001, 3);
    expect_rd(4'd4, 16'h0003, "R5");
    wr(4'd10, 16'h0007);
    pulse(3'b001, 1);
    expect_rd(4'd4, 16'h0003, "R5");
    pulse(3'b100, 1);
    expect_rd(4'd4, 16'h0002, "R5");

    cyc(1'b0, 4'd0, 16'd0, 3'b000);
    @(negedge clk);
    finish_run();
  end
endmodule